// File: doc/BRIEF.md
# Debug Command Decoder with Idle-Cycle RAM Reader

This block sits between an external debug receiver and the on-chip RAM. The receiver hands it one 32-bit command word at a time, marked by a one-cycle valid strobe. The block pulls the command code out of the word and decodes it. A read command makes it fetch one 32-bit word from RAM through a side port. That side port is used only in cycles where the CPU leaves the RAM idle, so the CPU never waits for a debug access.

The fetched word is placed in an output holding register with a valid flag. The transmitter clears that flag with an acknowledge pulse. A pair of all-ones words in a row is a recovery request, and it wipes the block's internal state. The command word that directly follows a recovery is accepted only if its upper twelve bits are all ones. The other command codes (verify, interrupt request, write) belong to neighbouring logic and have no effect here.

Top module: `dbg_cmd_reader`

## Requirements
- R1: A word with cmd_valid high and bits 18..16 equal to 3'b010 queues a RAM read whatever bit 19 is. The word address is bits 13..2 of the command. Bits 15..14 and 1..0 do not affect the address.
- R2: ram_rd_en is high only in cycles where cpu_ram_busy is low. It is high for exactly one cycle for each pending read, and during that cycle ram_rd_addr carries the pending address.
- R3: While cpu_ram_busy stays high, a pending read stays pending and no read is issued.
- R4: ram_rd_data is captured in the cycle after ram_rd_en. res_valid rises at the following clock edge, and res_data equals the captured word. With the RAM idle this gives two cycles from the command edge to res_valid.
- R5: Once res_valid is set, it and res_data stay unchanged until res_ack. A res_ack pulse clears res_valid at the next edge.
- R6: If a read command arrives while an earlier read is still pending, it replaces the pending address. Only one RAM read is issued, at the new address.
- R7: Codes 3'b000 (verify), 3'b100 (interrupt), 3'b110 (write) and every other code except 3'b010 in bits 18..16 cause no RAM read. They leave res_valid and res_data unchanged, provided the word is not all ones.
- R8: A single all-ones word followed by any other word does not cause recovery. A pending read survives it, and the following word is decoded normally.
- R9: Two all-ones words in succession cause recovery. Recovery drops any pending or in-flight read and clears res_valid at the next edge.
- R10: The first word after a recovery is ignored unless its bits 31..20 are all ones. This rule covers only that one word.
- R11: While reset is asserted and right after it, res_valid, ram_rd_en and res_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word strobe, one cycle per word |
| cmd_word | input | 32 | Received command word |
| cpu_ram_busy | input | 1 | CPU is using the RAM this cycle |
| ram_rd_en | output | 1 | Debug read enable toward RAM |
| ram_rd_addr | output | ADDR_BITS-2 | Word address of the debug read |
| ram_rd_data | input | 32 | RAM read data, valid the cycle after ram_rd_en |
| res_valid | output | 1 | Read result is held |
| res_data | output | 32 | Read result word |
| res_ack | input | 1 | Transmitter has taken the result |

## Verification
The read path is swept over every one of the 4096 word addresses. Bit 19 and the ignored bits 15..14 and 1..0 are varied throughout, and some addresses meet a busy RAM first. This separates correct address slicing from a shifted or widened slice, and correct idle-cycle waiting from issuing reads early. Every non-read code, with bit 19 both set and clear, is tried against a held result to show that nothing is disturbed. Finally, all-ones words are placed alone, in pairs, and in front of both well-formed and malformed follow-up words. This tells a true two-word recovery apart from a one-word trigger, and shows that the upper-bits rule applies only to the word right after recovery.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    localparam int CMD_W    = 32;
    localparam int CODE_LSB = 16;

    typedef enum logic [2:0] {
        OP_CHECK = 3'b000,
        OP_READ  = 3'b010,
        OP_IRQ   = 3'b100,
        OP_WRITE = 3'b110
    } op_e;

    typedef struct packed {
        logic rcv_half;
        logic post_rcv;
    } dec_st_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } stage_st_t;

endpackage

// File: rtl/dbgc_decode.sv
module dbgc_decode
    import dbgc_pkg::*;
#(
    parameter int ADDR_BITS = 14,
    localparam int AW = ADDR_BITS - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    output logic             recover
);

    dec_st_t st_d, st_q;
    logic    all_ones;
    logic    top_ok;
    logic    is_read;

    assign all_ones = &cmd_word;
    assign top_ok   = !st_q.post_rcv || (&cmd_word[CMD_W-1:20]);
    assign is_read  = (cmd_word[CODE_LSB+2:CODE_LSB] == OP_READ);
    assign rd_addr  = cmd_word[ADDR_BITS-1:2];

    always_comb begin
        st_d    = st_q;
        rd_req  = 1'b0;
        recover = 1'b0;
        if (cmd_valid) begin
            if (all_ones) begin
                if (st_q.rcv_half) begin
                    recover       = 1'b1;
                    st_d.rcv_half = 1'b0;
                    st_d.post_rcv = 1'b1;
                end else begin
                    st_d.rcv_half = 1'b1;
                    st_d.post_rcv = 1'b0;
                end
            end else begin
                st_d.rcv_half = 1'b0;
                st_d.post_rcv = 1'b0;
                rd_req        = top_ok && is_read;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && recover));

    assert_recover_needs_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        recover |-> $past(cmd_valid) && $past(&cmd_word));

endmodule

// File: rtl/dbgc_steal.sv
module dbgc_steal #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          recover,
    input  logic          cpu_ram_busy,
    output logic          ram_rd_en,
    output logic [AW-1:0] ram_rd_addr,
    output logic          cap_valid
);

    typedef struct packed {
        logic          pend;
        logic          cap;
        logic [AW-1:0] addr;
    } steal_st_t;

    steal_st_t st_d, st_q;
    logic      issue;

    assign issue       = st_q.pend && !cpu_ram_busy;
    assign ram_rd_en   = issue;
    assign ram_rd_addr = st_q.addr;
    assign cap_valid   = st_q.cap;

    always_comb begin
        st_d     = st_q;
        st_d.cap = issue && !recover;
        if (issue) st_d.pend = 1'b0;
        if (rd_req) begin
            st_d.pend = 1'b1;
            st_d.addr = rd_addr;
        end
        if (recover) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_pending_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && cpu_ram_busy && !recover) |=> st_q.pend);

    assert_capture_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd_en && !recover) |=> cap_valid);

    assert_single_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd_en && !rd_req) |=> !ram_rd_en);

endmodule

// File: rtl/dbgc_stage.sv
module dbgc_stage
    import dbgc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_valid,
    input  logic [31:0] cap_data,
    input  logic        recover,
    input  logic        res_ack,
    output logic        res_valid,
    output logic [31:0] res_data
);

    stage_st_t st_d, st_q;

    assign res_valid = st_q.valid;
    assign res_data  = st_q.data;

    always_comb begin
        st_d = st_q;
        if (recover) begin
            st_d.valid = 1'b0;
        end else if (cap_valid) begin
            st_d.valid = 1'b1;
            st_d.data  = cap_data;
        end else if (res_ack) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ack && !cap_valid) |=> !res_valid);

    assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ack && !cap_valid && !recover) |=> res_valid && $stable(res_data));

endmodule

// File: rtl/dbg_cmd_reader.sv
module dbg_cmd_reader
    import dbgc_pkg::*;
#(
    parameter int ADDR_BITS = 14,
    localparam int AW = ADDR_BITS - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             cpu_ram_busy,
    output logic             ram_rd_en,
    output logic [AW-1:0]    ram_rd_addr,
    input  logic [31:0]      ram_rd_data,
    output logic             res_valid,
    output logic [31:0]      res_data,
    input  logic             res_ack
);

    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          recover;
    logic          cap_valid;

    dbgc_decode #(.ADDR_BITS(ADDR_BITS)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .recover   (recover)
    );

    dbgc_steal #(.AW(AW)) u_steal (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .recover      (recover),
        .cpu_ram_busy (cpu_ram_busy),
        .ram_rd_en    (ram_rd_en),
        .ram_rd_addr  (ram_rd_addr),
        .cap_valid    (cap_valid)
    );

    dbgc_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_valid (cap_valid),
        .cap_data  (ram_rd_data),
        .recover   (recover),
        .res_ack   (res_ack),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    assert_no_steal_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd_en |-> !cpu_ram_busy);

    assert_recover_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        recover |=> !res_valid);

endmodule

// File: tb/test_dbg_cmd_reader.sv
module test_dbg_cmd_reader;

    localparam int AB = 14;
    localparam int AW = AB - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [31:0]   cmd_word = '0;
    logic          cpu_ram_busy = 1'b0;
    logic          ram_rd_en;
    logic [AW-1:0] ram_rd_addr;
    logic [31:0]   ram_rd_data;
    logic          res_valid;
    logic [31:0]   res_data;
    logic          res_ack = 1'b0;

    int n_total = 0;
    int n_fail  = 0;
    int en_cnt  = 0;
    int busy_violations = 0;
    bit done = 1'b0;
    logic [31:0] ram_q = '0;

    always #2.5 clk = ~clk;

    dbg_cmd_reader #(.ADDR_BITS(AB)) i_dbg_cmd_reader (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cpu_ram_busy(cpu_ram_busy), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
        .ram_rd_data(ram_rd_data), .res_valid(res_valid), .res_data(res_data),
        .res_ack(res_ack)
    );

    function automatic logic [31:0] memval(int a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] rd_cmd(logic [11:0] top, logic b19, logic [1:0] b15, int a, logic [1:0] lo);
        return {top, b19, 3'b010, b15, a[AW-1:0], lo};
    endfunction

    assign ram_rd_data = ram_q;
    always @(posedge clk) begin
        if (ram_rd_en) begin
            ram_q  <= memval(int'(ram_rd_addr));
            en_cnt <= en_cnt + 1;
            if (cpu_ram_busy) busy_violations <= busy_violations + 1;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(logic [31:0] w);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_res();
        for (int i = 0; i < 20; i++) begin
            if (res_valid) break;
            @(negedge clk);
        end
    endtask

    task automatic ack();
        res_ack = 1'b1;
        @(negedge clk);
        res_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        logic [31:0] held;

        repeat (3) @(negedge clk);
        // R11: state while in reset and right after release
        chk("R11 valid in reset", {31'd0, res_valid}, 32'd0);
        chk("R11 en in reset", {31'd0, ram_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 valid after reset", {31'd0, res_valid}, 32'd0);
        chk("R11 data after reset", res_data, 32'd0);
        chk("R11 en after reset", {31'd0, ram_rd_en}, 32'd0);

        // R4 / R2: exact latency with idle RAM
        send(rd_cmd(12'h000, 1'b0, 2'b00, 77, 2'b00));
        chk("R2 en in idle cycle", {31'd0, ram_rd_en}, 32'd1);
        chk("R2 address", {20'd0, ram_rd_addr}, 32'd77);
        chk("R4 not yet valid", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        chk("R2 single cycle", {31'd0, ram_rd_en}, 32'd0);
        chk("R4 still not valid", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        chk("R4 valid", {31'd0, res_valid}, 32'd1);
        chk("R4 data", res_data, memval(77));
        // R5: held until ack
        idle(4);
        chk("R5 held valid", {31'd0, res_valid}, 32'd1);
        chk("R5 held data", res_data, memval(77));
        ack();
        chk("R5 ack clears", {31'd0, res_valid}, 32'd0);

        // R1: sweep every word address with ignored bits varied
        for (int a = 0; a < (1 << AW); a++) begin
            base = en_cnt;
            if (a[1:0] == 2'b01) cpu_ram_busy = 1'b1;
            send(rd_cmd(a[11:0] ^ 12'h5A3, a[0], a[3:2], a, a[5:4]));
            if (a[1:0] == 2'b01) begin
                idle(3);
                chk("R3 no issue while busy", en_cnt, base);
                cpu_ram_busy = 1'b0;
            end
            wait_res();
            chk("R1 sweep data", res_data, memval(a));
            ack();
            chk("R2 one read per command", en_cnt, base + 1);
        end

        // R6: replacement of a pending address
        base = en_cnt;
        cpu_ram_busy = 1'b1;
        send(rd_cmd(12'h000, 1'b0, 2'b00, 100, 2'b00));
        send(rd_cmd(12'h000, 1'b1, 2'b00, 200, 2'b00));
        idle(2);
        cpu_ram_busy = 1'b0;
        wait_res();
        chk("R6 new address wins", res_data, memval(200));
        idle(3);
        chk("R6 single read", en_cnt, base + 1);

        // R7: every non-read code leaves held result untouched (result 200 not acked)
        held = res_data;
        for (int c = 0; c < 16; c++) begin
            if (c[2:0] != 3'b010) begin
                base = en_cnt;
                send({12'h123, c[3:0], 16'h0040});
                idle(4);
                chk("R7 no read", en_cnt, base);
                chk("R7 valid kept", {31'd0, res_valid}, 32'd1);
                chk("R7 data kept", res_data, held);
            end
        end
        ack();

        // R8: lone all-ones word keeps pending read and valid result
        cpu_ram_busy = 1'b1;
        send(rd_cmd(12'h000, 1'b0, 2'b00, 300, 2'b00));
        send(32'hFFFF_FFFF);
        send(32'h0000_0000);
        idle(2);
        cpu_ram_busy = 1'b0;
        wait_res();
        chk("R8 pending survived", res_data, memval(300));
        send(32'hFFFF_FFFF);
        send(rd_cmd(12'h000, 1'b0, 2'b00, 301, 2'b00));
        idle(3);
        chk("R8 valid not cleared", {31'd0, res_valid}, 32'd1);
        chk("R8 next word decoded", res_data, memval(301));
        ack();

        // R9: recovery drops pending read and valid result
        send(rd_cmd(12'h000, 1'b0, 2'b00, 400, 2'b00));
        wait_res();
        cpu_ram_busy = 1'b1;
        send(rd_cmd(12'h000, 1'b0, 2'b00, 401, 2'b00));
        send(32'hFFFF_FFFF);
        send(32'hFFFF_FFFF);
        chk("R9 valid cleared", {31'd0, res_valid}, 32'd0);
        base = en_cnt;
        cpu_ram_busy = 1'b0;
        idle(6);
        chk("R9 pending dropped", en_cnt, base);
        chk("R9 no result", {31'd0, res_valid}, 32'd0);

        // R10: first word after recovery needs upper ones; only that word
        send(rd_cmd(12'h000, 1'b0, 2'b00, 500, 2'b00));
        idle(6);
        chk("R10 malformed ignored", en_cnt, base);
        chk("R10 no result", {31'd0, res_valid}, 32'd0);
        send(rd_cmd(12'h000, 1'b0, 2'b00, 501, 2'b00));
        wait_res();
        chk("R10 rule one word only", res_data, memval(501));
        ack();
        send(32'hFFFF_FFFF);
        send(32'hFFFF_FFFF);
        send(rd_cmd(12'hFFF, 1'b0, 2'b00, 502, 2'b11));
        wait_res();
        chk("R10 upper ones accepted", res_data, memval(502));
        ack();

        chk("R2 never read while busy", busy_violations, 0);
        finish_run();
    end

endmodule